// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block sits behind a serial receiver front end and moves each received byte into memory buffers that software sets up. The buffers are described by a ring of 8-byte descriptors in a shared, word-addressed RAM. Each descriptor has three parts. The first is a 16-bit status/control word. The second is a 16-bit length word at byte offset 2. The third is a 32-bit buffer pointer at offsets 4 (high half) and 6 (low half). In the status word, descriptor bit 0 is the most significant bit, [15]. The block fetches the current descriptor and checks that it owns the descriptor. It then writes incoming bytes one at a time through byte enables and closes the buffer when the message ends or the buffer fills. On close it writes the length and status back, may signal software, and moves to the next descriptor. The ring has no length register: a wrap flag in a descriptor sends the engine back to the table base.

The controller has eight states:

- IDLE waits for work.
- RD_STAT, RD_PHI and RD_PLO read the descriptor's status word and the two halves of its pointer. Reads have one cycle of latency.
- CHECK tests ownership.
- WR_BYTE stores one byte.
- CLOSE_LEN writes the length word.
- CLOSE_STAT writes the status word and advances the ring.

The transitions are:

- IDLE goes to RD_STAT when a byte is pending and no buffer is open. It goes to WR_BYTE when a byte is pending and a buffer is open.
- IDLE goes to CLOSE_LEN when a framing event or overrun is pending and a buffer is open. It stays in IDLE, discarding the event, when no buffer is open.
- RD_STAT goes to RD_PHI, RD_PHI goes to RD_PLO and RD_PLO goes to CHECK.
- CHECK goes to WR_BYTE when the descriptor is owned. Otherwise it goes to IDLE and drops the byte as busy.
- WR_BYTE goes to CLOSE_LEN when the buffer becomes full, and to IDLE otherwise.
- CLOSE_LEN goes to CLOSE_STAT, and CLOSE_STAT goes to IDLE.

The front end has no handshake. It must space bytes and events at least 12 clock cycles apart. The maximum length input must stay constant while a buffer is open.

Top module: `rx_desc_ring`

## Requirements
- R1: Out of reset the block issues no memory request and raises no event, and its first descriptor fetch reads the word at the table base (byte address `cfg_ring_base`).
- R2: A byte arriving with no open buffer makes the block read the descriptor's status word, then its pointer high word (byte offset 4), then its pointer low word (byte offset 6), in that order.
- R3: If the fetched status word has the ownership bit [15] clear, the byte is dropped and nothing is written to memory. `evt_busy` pulses for one cycle. The next byte fetches the same descriptor again.
- R4: The n-th byte of a buffer (counting from 0) is written to byte address pointer+n. An even byte address uses the high lane (`mem_be`=2'b10, data on [15:8]). An odd byte address uses the low lane (`mem_be`=2'b01, data on [7:0]).
- R5: A framing event (`rx_frame_evt`, a stop or start condition) closes the open buffer with the final-character flag [11] set.
- R6: An overrun closes the open buffer with both [11] and the overrun flag [1] set. A byte that arrives in the same cycle as the overrun is stored before the buffer closes.
- R7: When the byte count reaches `cfg_max_len`, the buffer closes with [11] and [1] clear. The bytes that follow go to the next descriptor.
- R8: On close, the byte count is written to the length word, and then the status word is written. The status word has [15] clear, the wrap bit [13] and notify bit [12] as fetched, [11] and [1] as closed, and every other bit zero.
- R9: `evt_rxbuf` pulses for exactly one cycle when a buffer closes whose notify bit [12] is set. It does not pulse when [12] is clear.
- R10: After closing a descriptor with wrap bit [13] set, the next fetch is at the table base. Otherwise it is at the following 8-byte slot.
- R11: A framing event or overrun that arrives with no open buffer causes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ring_base | input | ADDR_W | Byte address of the first descriptor |
| cfg_max_len | input | 16 | Byte count at which a buffer is closed as full |
| rx_valid | input | 1 | One-cycle strobe: `rx_data` holds a received byte |
| rx_data | input | 8 | Received byte |
| rx_frame_evt | input | 1 | One-cycle strobe: stop or start condition seen on the bus |
| rx_overrun | input | 1 | One-cycle strobe: receiver overrun |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W-1 | Word address |
| mem_be | output | 2 | Byte enables, [1] = even (high) byte |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after a read request |
| evt_rxbuf | output | 1 | One-cycle pulse: a buffer with its notify bit set was closed |
| evt_busy | output | 1 | One-cycle pulse: a byte was dropped because the descriptor was not owned |

## Verification
On every cycle, the embedded assertions check these properties:

- A lane write enables exactly one byte.
- A status write-back always follows the length write and carries no stray bits.
- A busy drop never writes memory.
- Notify pulses last a single cycle.
- A stray framing event causes no access.
- The byte count steps by one and stays within the maximum.
- The ring address either steps by 8 bytes or returns to the base.

Only the directed scenarios can show the buffer contents and written-back descriptors. Those scenarios cover the split of one message across a full buffer and its successor, wrapping back to a descriptor software still holds, retrying it once it is handed back, and storing a byte that arrives together with an overrun before that overrun is recorded.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_STAT,
        S_RD_PHI,
        S_RD_PLO,
        S_CHECK,
        S_WR_BYTE,
        S_CLOSE_LEN,
        S_CLOSE_STAT
    } rdr_state_e;

    // Status word bit positions; descriptor bit 0 maps to [15]
    localparam int ST_OWN   = 15;
    localparam int ST_WRAP  = 13;
    localparam int ST_NOTE  = 12;
    localparam int ST_FINAL = 11;
    localparam int ST_OVR   = 1;

    localparam logic [15:0] ST_RSV_MASK = 16'h47FD;
    localparam int          DESC_BYTES  = 8;
    localparam int          LEN_W       = 16;
endpackage

// File: rtl/rdr_evt_latch.sv
module rdr_evt_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_frame_evt,
    input  logic       rx_overrun,
    input  logic       take_byte,
    input  logic       take_close,
    output logic       byte_pend,
    output logic [7:0] byte_q,
    output logic       close_pend,
    output logic       ovr_pend
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_pend  <= 1'b0;
            byte_q     <= '0;
            close_pend <= 1'b0;
            ovr_pend   <= 1'b0;
        end else begin
            if (rx_valid) begin
                byte_pend <= 1'b1;
                byte_q    <= rx_data;
            end else if (take_byte) begin
                byte_pend <= 1'b0;
            end

            if (rx_frame_evt || rx_overrun) begin
                close_pend <= 1'b1;
                ovr_pend   <= ovr_pend | rx_overrun;
            end else if (take_close) begin
                close_pend <= 1'b0;
                ovr_pend   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rdr_ring_ptr.sv
module rdr_ring_ptr #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base,
    input  logic              advance,
    input  logic              wrap,
    output logic [ADDR_W-1:0] desc_addr
);
    localparam int SLOT_SHIFT = $clog2(rdr_pkg::DESC_BYTES);

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (advance) begin
            idx_q <= wrap ? '0 : idx_q + 1'b1;
        end
    end

    assign desc_addr = base + ADDR_W'({idx_q, {SLOT_SHIFT{1'b0}}});

    assert_wrap_to_base_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && wrap) |=> (desc_addr == $past(base)));

    assert_step_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !wrap && $stable(base) && (idx_q != '1)) |=>
        (desc_addr == $past(desc_addr) + ADDR_W'(rdr_pkg::DESC_BYTES)));
endmodule

// File: rtl/rdr_fill.sv
module rdr_fill #(
    parameter int ADDR_W = 12,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  logic [ADDR_W-1:0] buf_base,
    input  logic [LEN_W-1:0]  max_len,
    output logic [LEN_W-1:0]  count,
    output logic [ADDR_W-2:0] waddr,
    output logic              lane_hi,
    output logic              at_limit
);
    logic [ADDR_W-1:0] baddr;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (wr) begin
            count <= count + 1'b1;
        end
    end

    assign baddr    = buf_base + ADDR_W'(count);
    assign waddr    = baddr[ADDR_W-1:1];
    assign lane_hi  = !baddr[0];
    assign at_limit = ((count + LEN_W'(1)) == max_len);

    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |=> (count == $past(count) + LEN_W'(1)));

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (max_len != '0 && $stable(max_len) && $past(count) < max_len) |-> (count <= max_len));
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
    import rdr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_ring_base,
    input  logic [15:0]       cfg_max_len,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_frame_evt,
    input  logic              rx_overrun,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-2:0] mem_addr,
    output logic [1:0]        mem_be,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    output logic              evt_rxbuf,
    output logic              evt_busy
);
    localparam int WA_W = ADDR_W - 1;

    rdr_state_e state, nxt;

    logic              byte_pend, close_pend, ovr_pend;
    logic [7:0]        byte_q;
    logic              take_byte, take_close;
    logic              fill_clr, fill_wr, ring_adv;
    logic [ADDR_W-1:0] desc_addr;
    logic [WA_W-1:0]   desc_w;
    logic [LEN_W-1:0]  fill_count;
    logic [WA_W-1:0]   fill_waddr;
    logic              lane_hi, at_limit;

    logic [15:0]       stat_q;
    logic [15:0]       ptr_hi_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [31:0]       ptr_full;
    logic              open_q, last_q, ovr_q;
    logic [15:0]       stat_wb;
    logic              unused_bits;

    rdr_evt_latch u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rx_frame_evt(rx_frame_evt),
        .rx_overrun  (rx_overrun),
        .take_byte   (take_byte),
        .take_close  (take_close),
        .byte_pend   (byte_pend),
        .byte_q      (byte_q),
        .close_pend  (close_pend),
        .ovr_pend    (ovr_pend)
    );

    rdr_ring_ptr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .base     (cfg_ring_base),
        .advance  (ring_adv),
        .wrap     (stat_q[ST_WRAP]),
        .desc_addr(desc_addr)
    );

    rdr_fill #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fill (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (fill_clr),
        .wr      (fill_wr),
        .buf_base(ptr_q),
        .max_len (cfg_max_len),
        .count   (fill_count),
        .waddr   (fill_waddr),
        .lane_hi (lane_hi),
        .at_limit(at_limit)
    );

    assign desc_w   = desc_addr[ADDR_W-1:1];
    assign ptr_full = {ptr_hi_q, mem_rdata};
    assign stat_wb  = {1'b0, 1'b0, stat_q[ST_WRAP], stat_q[ST_NOTE], last_q,
                       9'b0, ovr_q, 1'b0};
    assign unused_bits = ^{ptr_full[31:ADDR_W], desc_addr[0], stat_q[14], stat_q[11:0]};

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Descriptor working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q   <= '0;
            ptr_hi_q <= '0;
            ptr_q    <= '0;
            open_q   <= 1'b0;
            last_q   <= 1'b0;
            ovr_q    <= 1'b0;
        end else begin
            if (state == S_RD_PHI) stat_q   <= mem_rdata;
            if (state == S_RD_PLO) ptr_hi_q <= mem_rdata;
            if (state == S_CHECK) begin
                ptr_q  <= ptr_full[ADDR_W-1:0];
                open_q <= stat_q[ST_OWN];
            end
            if (state == S_IDLE && !byte_pend && close_pend && open_q) begin
                last_q <= 1'b1;
                ovr_q  <= ovr_pend;
            end
            if (state == S_WR_BYTE && at_limit) begin
                last_q <= 1'b0;
                ovr_q  <= 1'b0;
            end
            if (state == S_CLOSE_STAT) open_q <= 1'b0;
        end
    end

    // Next state and outputs
    always_comb begin
        nxt        = state;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = desc_w;
        mem_be     = 2'b11;
        mem_wdata  = '0;
        take_byte  = 1'b0;
        take_close = 1'b0;
        fill_clr   = 1'b0;
        fill_wr    = 1'b0;
        ring_adv   = 1'b0;
        evt_rxbuf  = 1'b0;
        evt_busy   = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (byte_pend) begin
                    nxt = open_q ? S_WR_BYTE : S_RD_STAT;
                end else if (close_pend) begin
                    take_close = 1'b1;
                    if (open_q) nxt = S_CLOSE_LEN;
                end
            end
            S_RD_STAT: begin
                mem_req = 1'b1;
                nxt     = S_RD_PHI;
            end
            S_RD_PHI: begin
                mem_req  = 1'b1;
                mem_addr = desc_w + WA_W'(2);
                nxt      = S_RD_PLO;
            end
            S_RD_PLO: begin
                mem_req  = 1'b1;
                mem_addr = desc_w + WA_W'(3);
                nxt      = S_CHECK;
            end
            S_CHECK: begin
                if (stat_q[ST_OWN]) begin
                    fill_clr = 1'b1;
                    nxt      = S_WR_BYTE;
                end else begin
                    take_byte = 1'b1;
                    evt_busy  = 1'b1;
                    nxt       = S_IDLE;
                end
            end
            S_WR_BYTE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = fill_waddr;
                mem_be    = lane_hi ? 2'b10 : 2'b01;
                mem_wdata = {byte_q, byte_q};
                take_byte = 1'b1;
                fill_wr   = 1'b1;
                nxt       = at_limit ? S_CLOSE_LEN : S_IDLE;
            end
            S_CLOSE_LEN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_w + WA_W'(1);
                mem_wdata = fill_count;
                nxt       = S_CLOSE_STAT;
            end
            S_CLOSE_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = stat_wb;
                evt_rxbuf = stat_q[ST_NOTE];
                ring_adv  = 1'b1;
                nxt       = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    assert_busy_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_busy |-> !mem_we);

    assert_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && fill_wr) |-> ($countones(mem_be) == 1));

    assert_len_then_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CLOSE_STAT) |-> ($past(state) == S_CLOSE_LEN));

    assert_status_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_adv && mem_we) |-> (((mem_wdata & ST_RSV_MASK) == 16'h0) && !mem_wdata[ST_OWN]));

    assert_rxbuf_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rxbuf |=> !evt_rxbuf);

    assert_stray_close_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !byte_pend && close_pend && !open_q) |=> !mem_req);
endmodule

// File: tb/rx_desc_ring_bench.sv
module rx_desc_ring_bench;
    localparam int AW   = 12;
    localparam int BASE = 12'h100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_ring_base = AW'(BASE);
    logic [15:0]   cfg_max_len = 16'd8;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          rx_frame_evt = 1'b0;
    logic          rx_overrun = 1'b0;
    logic          mem_req, mem_we;
    logic [AW-2:0] mem_addr;
    logic [1:0]    mem_be;
    logic [15:0]   mem_wdata;
    logic [15:0]   mem_rdata = '0;
    logic          evt_rxbuf, evt_busy;

    int checks = 0;
    int failures = 0;
    int wr_cnt = 0;
    int req_cnt = 0;
    int rxbuf_cnt = 0;
    int busy_cnt = 0;
    logic [AW-2:0] first_rd = '0;
    logic          seen_rd = 1'b0;
    logic [15:0]   mem [0:2047];

    always #2 clk = ~clk;

    rx_desc_ring #(.ADDR_W(AW), .IDX_W(8)) u_rx_desc_ring (
        .clk(clk), .rst_n(rst_n), .cfg_ring_base(cfg_ring_base), .cfg_max_len(cfg_max_len),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_frame_evt(rx_frame_evt),
        .rx_overrun(rx_overrun), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .evt_rxbuf(evt_rxbuf), .evt_busy(evt_busy)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            req_cnt <= req_cnt + 1;
            if (mem_we) begin
                if (mem_be[1]) mem[mem_addr][15:8] <= mem_wdata[15:8];
                if (mem_be[0]) mem[mem_addr][7:0]  <= mem_wdata[7:0];
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr];
                if (!seen_rd) begin
                    first_rd <= mem_addr;
                    seen_rd  <= 1'b1;
                end
            end
        end
        if (rst_n && evt_rxbuf) rxbuf_cnt <= rxbuf_cnt + 1;
        if (rst_n && evt_busy)  busy_cnt  <= busy_cnt + 1;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(input int addr);
        logic [15:0] w = mem[addr >> 1];
        return (addr % 2 == 1) ? w[7:0] : w[15:8];
    endfunction

    task automatic set_desc(input int idx, input logic [15:0] st, input logic [31:0] ptr);
        int w = (BASE >> 1) + idx * 4;
        mem[w]     = st;
        mem[w + 1] = 16'h0;
        mem[w + 2] = ptr[31:16];
        mem[w + 3] = ptr[15:0];
    endtask

    task automatic send_byte(input logic [7:0] b, input logic ovr);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b; rx_overrun = ovr;
        @(negedge clk);
        rx_valid = 1'b0; rx_overrun = 1'b0;
        repeat (16) @(negedge clk);
    endtask

    task automatic send_evt(input logic frame, input logic ovr);
        @(negedge clk);
        rx_frame_evt = frame; rx_overrun = ovr;
        @(negedge clk);
        rx_frame_evt = 1'b0; rx_overrun = 1'b0;
        repeat (16) @(negedge clk);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1", "mem_req after reset", 32'(mem_req), 32'd0);
            chk("R1", "events after reset", 32'({evt_rxbuf, evt_busy}), 32'd0);
        end
    endtask

    task automatic t_frame_close;
        send_byte(8'hA1, 1'b0);
        chk("R1", "first fetch word", 32'(first_rd), 32'(BASE >> 1));
        send_byte(8'hA2, 1'b0);
        send_byte(8'hA3, 1'b0);
        send_evt(1'b1, 1'b0);
        chk("R4", "byte 0x400", 32'(mbyte(12'h400)), 32'hA1);
        chk("R4", "byte 0x401", 32'(mbyte(12'h401)), 32'hA2);
        chk("R2", "byte 0x402 via fetched pointer", 32'(mbyte(12'h402)), 32'hA3);
        chk("R8", "d0 length", 32'(mem[12'h81]), 32'd3);
        chk("R5", "d0 status final set, reserved cleared", 32'(mem[12'h80]), 32'h1800);
        chk("R9", "notify pulses", 32'(rxbuf_cnt), 32'd1);
    endtask

    task automatic t_full_split;
        for (int i = 0; i < 10; i++) send_byte(8'(8'h10 + i), 1'b0);
        for (int i = 0; i < 8; i++)
            chk("R4", "d1 buffer byte", 32'(mbyte(12'h501 + i)), 32'(8'h10 + i));
        chk("R4", "high lane untouched at 0x500", 32'(mbyte(12'h500)), 32'hEE);
        chk("R7", "d1 length at limit", 32'(mem[12'h85]), 32'd8);
        chk("R7", "d1 status no final flag", 32'(mem[12'h84]), 32'h0000);
        chk("R9", "no pulse when notify clear", 32'(rxbuf_cnt), 32'd1);
        chk("R7", "spill byte 0x600", 32'(mbyte(12'h600)), 32'h18);
        chk("R7", "spill byte 0x601", 32'(mbyte(12'h601)), 32'h19);
        send_evt(1'b1, 1'b0);
        chk("R8", "d2 length", 32'(mem[12'h89]), 32'd2);
        chk("R8", "d2 status keeps wrap and notify", 32'(mem[12'h88]), 32'h3800);
        chk("R9", "notify pulse for d2", 32'(rxbuf_cnt), 32'd2);
    endtask

    task automatic t_busy_retry;
        int w0 = wr_cnt;
        send_byte(8'h77, 1'b0);
        chk("R3", "no write on busy", 32'(wr_cnt), 32'(w0));
        chk("R3", "busy pulses", 32'(busy_cnt), 32'd1);
        chk("R10", "old d0 data kept", 32'(mbyte(12'h400)), 32'hA1);
        set_desc(0, 16'h8000, 32'h0000_0700);
        send_byte(8'h5A, 1'b0);
        send_byte(8'h5B, 1'b1);
        chk("R10", "wrapped to base, byte 0x700", 32'(mbyte(12'h700)), 32'h5A);
        chk("R6", "byte with overrun stored", 32'(mbyte(12'h701)), 32'h5B);
        chk("R6", "d0 length", 32'(mem[12'h81]), 32'd2);
        chk("R6", "d0 status final and overrun", 32'(mem[12'h80]), 32'h0802);
        chk("R9", "no pulse for d0", 32'(rxbuf_cnt), 32'd2);
        chk("R3", "no further busy", 32'(busy_cnt), 32'd1);
    endtask

    task automatic t_stray_events;
        int r0 = req_cnt;
        send_evt(1'b1, 1'b0);
        send_evt(1'b0, 1'b1);
        chk("R11", "no access on stray events", 32'(req_cnt), 32'(r0));
        chk("R11", "no notify on stray events", 32'(rxbuf_cnt), 32'd2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 16'h0;
        mem[12'h280] = 16'hEEEE;
        set_desc(0, 16'hD001, 32'h0000_0400);
        set_desc(1, 16'h8000, 32'h0000_0501);
        set_desc(2, 16'hB000, 32'h0000_0600);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_frame_close();
        t_full_split();
        t_busy_retry();
        t_stray_events();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule